// File: doc/BRIEF.md
# RTC Update Cycle and Interrupt Flag Controller

This block sequences the once-per-second update of a PC-style real-time clock and owns its interrupt flags. A 1 Hz tick starts a two-phase timed update. A microsecond strobe paces the phases. In the first phase the update-in-progress bit is raised. At the end of that phase the time bytes advance and are compared with the alarm bytes. At the end of the second phase the update-ended flag is posted.

A periodic divider runs from a 32.768 kHz strobe and posts a periodic flag. The interrupt line is the OR of the pending flags that are enabled, and it is re-evaluated on every flag event, on every control write and on every status read.

The host reaches the block through a simple register bus. Writes take effect on the clock edge. Reads are combinational, and the status register clears when it is read. Calendar arithmetic is reduced to a stub: seconds count modulo 60 and carry into minutes.

Top module: `rtc_update_irq`

## Requirements
- R1: A 1 Hz tick starts an update cycle only when control A bits 6:4 equal 3'b010 and the SET bit (control B bit 7) is 0, and no cycle is active; otherwise the tick has no effect.
- R2: Starting a cycle sets UIP (control A bit 7) on the tick edge. Exactly LOAD_US microsecond strobes later (default 244), the time advances: seconds go up by 1, wrap from 59 to 0, and carry into minutes (59 wraps to 0).
- R3: When the time advances, the new seconds and minutes, together with hours, day and month, are compared with the five alarm bytes. If all five match, AF (status bit 5) is set.
- R4: Exactly END_US strobes after the time advance (default 1984), UF (status bit 4) is set and UIP clears. A tick during an active cycle neither restarts nor extends it.
- R5: IRQF (status bit 7) and irq_o equal the OR of (B[6:4] & status[6:4]), where PIE=B6, AIE=B5 and UIE=B4. They are re-evaluated after every flag set and every B write.
- R6: A read of the status register (address 0xC) returns {IRQF, PF, AF, UF, 4'b0000} and then clears those bits, so irq_o drops. A flag set in the same cycle as the read survives.
- R7: A B write that takes SET from 0 to 1 stores UIE as 0, clears UIP and abandons the active cycle. The time bytes do not advance and UF is not set.
- R8: Writes to the status register are ignored. Writes to control A leave UIP at its internal value.
- R9: Seconds (address 0x0) bit 7 is always stored as 0.
- R10: PF (status bit 6) is set every 2^(n-1) periodic strobes, where n is the rate in A[3:0]. Rates 1 and 2 act as 8 and 9, and rate 0 stops the divider. A write to A restarts the count.
- R11: After reset, the status register reads 0, UIP is 0 and irq_o is low.

Address map: 0x0 sec, 0x1 sec alarm, 0x2 min, 0x3 min alarm, 0x4 hour, 0x5 hour alarm, 0x6 day, 0x7 month, 0x8 day alarm, 0x9 month alarm, 0xA control A, 0xB control B, 0xC status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_1hz_i | input | 1 | Once-per-second strobe |
| us_tick_i | input | 1 | Microsecond strobe |
| base_tick_i | input | 1 | 32.768 kHz strobe for the periodic divider |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (read-to-clear side effect) |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| uip_o | output | 1 | Update in progress |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is a SET write that lands while an update cycle is in progress. The write must fall between the tick and the time advance, or the abort is never seen. The bench counts strobes from the tick and issues the B write a few cycles into the first phase. It then waits well past both phase ends and confirms that the seconds did not move and that no UF appeared. Exact phase edges are also hard to hit. To reach them, the microsecond strobe is held high and the outputs are sampled one cycle before and one cycle after each boundary.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [3:0] {
    A_SEC = 4'h0, A_ASEC = 4'h1, A_MIN = 4'h2, A_AMIN = 4'h3,
    A_HOUR = 4'h4, A_AHOUR = 4'h5, A_DAY = 4'h6, A_MON = 4'h7,
    A_ADAY = 4'h8, A_AMON = 4'h9, A_CTLA = 4'hA, A_CTLB = 4'hB,
    A_STAT = 4'hC
  } reg_addr_e;

  localparam int unsigned B_SET = 7;
  localparam int unsigned B_UIE = 4;
  localparam logic [2:0] DIV_RUN = 3'b010;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_LOAD, SEQ_END} seq_state_e;
endpackage

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
  import rtc_pkg::*;
#(
  parameter int unsigned LOAD_US = 244,
  parameter int unsigned END_US  = 1984
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic enable_i,
  input  logic abort_i,
  input  logic us_tick_i,
  output logic uip_o,
  output logic load_o,
  output logic done_o
);
  localparam int unsigned MAXD = (LOAD_US > END_US) ? LOAD_US : END_US;
  localparam int unsigned CW   = $clog2(MAXD + 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;

  assign uip_o  = (state_q != SEQ_IDLE);
  assign load_o = (state_q == SEQ_LOAD) && us_tick_i && !abort_i &&
                  (cnt_q == CW'(LOAD_US - 1));
  assign done_o = (state_q == SEQ_END) && us_tick_i && !abort_i &&
                  (cnt_q == CW'(END_US - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else if (abort_i) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (tick_i && enable_i) begin
          state_q <= SEQ_LOAD;
          cnt_q   <= '0;
        end
        SEQ_LOAD: if (load_o) begin
          state_q <= SEQ_END;
          cnt_q   <= '0;
        end else if (us_tick_i) cnt_q <= cnt_q + 1'b1;
        SEQ_END: if (done_o) begin
          state_q <= SEQ_IDLE;
          cnt_q   <= '0;
        end else if (us_tick_i) cnt_q <= cnt_q + 1'b1;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assert_no_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !uip_o) |=> !uip_o);
  assert_end_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !uip_o);
  assert_abort_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !uip_o);
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_tick_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              restart_i,
  output logic              pf_o
);
  localparam int unsigned CNT_W = (1 << RATE_W) - 2;

  logic [CNT_W-1:0]  cnt_q;
  logic [RATE_W-1:0] eff;
  logic [CNT_W:0]    period;
  logic              match;

  always_comb begin
    eff = rate_i;
    if (rate_i == RATE_W'(1)) eff = RATE_W'(8);
    if (rate_i == RATE_W'(2)) eff = RATE_W'(9);
    period = (CNT_W+1)'(1) << (eff - 1'b1);
  end

  assign match = ({1'b0, cnt_q} == period - 1'b1);
  assign pf_o  = (rate_i != '0) && base_tick_i && !restart_i && match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (restart_i || rate_i == '0) cnt_q <= '0;
    else if (base_tick_i) cnt_q <= match ? '0 : cnt_q + 1'b1;
  end

  assert_rate0_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == '0) |-> !pf_o);
endmodule

// File: rtl/rtc_update_irq.sv
module rtc_update_irq
  import rtc_pkg::*;
#(
  parameter int unsigned LOAD_US = 244,
  parameter int unsigned END_US  = 1984,
  parameter int unsigned RATE_W  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_1hz_i,
  input  logic       us_tick_i,
  input  logic       base_tick_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       uip_o,
  output logic       irq_o
);
  logic [7:0] sec_q, min_q, hour_q, day_q, mon_q;
  logic [7:0] asec_q, amin_q, ahour_q, aday_q, amon_q;
  logic [6:0] a_q;
  logic [7:0] b_q, b_d;
  logic [2:0] flags_q, flags_d, flag_set;  // {PF, AF, UF}
  logic       irqf_q, irqf_d;
  logic       load, done, pf, set_rise, wr_a, wr_b, rd_c, run_ok;
  logic [7:0] new_sec, new_min;
  logic       carry, alarm_hit;

  assign wr_a     = wr_en_i && (addr_i == A_CTLA);
  assign wr_b     = wr_en_i && (addr_i == A_CTLB);
  assign rd_c     = rd_en_i && (addr_i == A_STAT);
  assign set_rise = wr_b && wdata_i[B_SET] && !b_q[B_SET];
  assign run_ok   = (a_q[6:4] == DIV_RUN) && !b_q[B_SET];

  rtc_update_seq #(.LOAD_US(LOAD_US), .END_US(END_US)) i_seq (
    .clk_i, .rst_ni, .tick_i(tick_1hz_i), .enable_i(run_ok),
    .abort_i(set_rise), .us_tick_i, .uip_o, .load_o(load), .done_o(done));

  rtc_periodic #(.RATE_W(RATE_W)) i_per (
    .clk_i, .rst_ni, .base_tick_i, .rate_i(a_q[RATE_W-1:0]),
    .restart_i(wr_a), .pf_o(pf));

  // time stub: seconds mod 60 with carry into minutes
  always_comb begin
    carry     = (sec_q >= 8'd59);
    new_sec   = carry ? 8'd0 : sec_q + 8'd1;
    new_min   = carry ? ((min_q >= 8'd59) ? 8'd0 : min_q + 8'd1) : min_q;
    alarm_hit = load && (new_sec == asec_q) && (new_min == amin_q) &&
                (hour_q == ahour_q) && (day_q == aday_q) && (mon_q == amon_q);
  end

  always_comb begin
    b_d = b_q;
    if (wr_b) begin
      b_d = wdata_i;
      if (set_rise) b_d[B_UIE] = 1'b0;
    end
    flag_set = {pf, alarm_hit, done};
    flags_d  = (rd_c ? 3'b000 : flags_q) | flag_set;
    irqf_d   = |(b_d[6:4] & flags_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {sec_q, min_q, hour_q, day_q, mon_q}       <= '0;
      {asec_q, amin_q, ahour_q, aday_q, amon_q}  <= '0;
      a_q     <= '0;
      b_q     <= '0;
      flags_q <= '0;
      irqf_q  <= 1'b0;
    end else begin
      b_q     <= b_d;
      flags_q <= flags_d;
      irqf_q  <= irqf_d;
      if (load) begin
        sec_q <= new_sec;
        min_q <= new_min;
      end
      if (wr_en_i) begin
        unique case (addr_i)
          A_SEC:   sec_q   <= {1'b0, wdata_i[6:0]};
          A_ASEC:  asec_q  <= wdata_i;
          A_MIN:   min_q   <= wdata_i;
          A_AMIN:  amin_q  <= wdata_i;
          A_HOUR:  hour_q  <= wdata_i;
          A_AHOUR: ahour_q <= wdata_i;
          A_DAY:   day_q   <= wdata_i;
          A_MON:   mon_q   <= wdata_i;
          A_ADAY:  aday_q  <= wdata_i;
          A_AMON:  amon_q  <= wdata_i;
          A_CTLA:  a_q     <= wdata_i[6:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_SEC:   rdata_o = sec_q;
      A_ASEC:  rdata_o = asec_q;
      A_MIN:   rdata_o = min_q;
      A_AMIN:  rdata_o = amin_q;
      A_HOUR:  rdata_o = hour_q;
      A_AHOUR: rdata_o = ahour_q;
      A_DAY:   rdata_o = day_q;
      A_MON:   rdata_o = mon_q;
      A_ADAY:  rdata_o = aday_q;
      A_AMON:  rdata_o = amon_q;
      A_CTLA:  rdata_o = {uip_o, a_q};
      A_CTLB:  rdata_o = b_q;
      A_STAT:  rdata_o = {irqf_q, flags_q, 4'b0000};
      default: rdata_o = 8'h00;
    endcase
  end

  assign irq_o = irqf_q;

  assert_irq_or_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(b_q[6:4] & flags_q));
  assert_rdclr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_c && flag_set == 3'b000) |=> (flags_q == 3'b000 && !irq_o));
  assert_stat_ro_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_STAT && !rd_en_i && flag_set == 3'b000) |=> $stable(flags_q));
  assert_set_uie_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_rise |=> (!b_q[B_UIE] && !uip_o));
  assert_set_blocks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_1hz_i && b_q[B_SET] && !uip_o) |=> !uip_o);
  assert_sec_msb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_SEC) |=> !sec_q[7]);
endmodule

// File: tb/test_rtc_update_irq.sv
module test_rtc_update_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, us = 1'b1, base = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       uip, irq;
  int         n_run = 0, n_fail = 0;
  bit         finished = 0;

  always #2 clk = ~clk;

  rtc_update_irq i_rtc_update_irq (
    .clk_i(clk), .rst_ni(rst_n), .tick_1hz_i(tick), .us_tick_i(us),
    .base_tick_i(base), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .uip_o(uip), .irq_o(irq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_stat(output logic [7:0] d);
    @(negedge clk);
    addr = 4'hC; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_tick;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic logic exp_irq(input logic [7:0] b, input logic [2:0] f);
    return |(b[6:4] & f);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, sec0, min0, b, asec, amin;
    logic       hit, mis;
    void'($urandom(32'h5eed_1234));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R11 reset state
    peek(4'hC, v); check(v == 8'h00, "R11 status", v, 0);
    check(!irq && !uip, "R11 irq/uip", {irq, uip}, 0);

    // R9 seconds msb
    wr(4'h0, 8'hFF); peek(4'h0, v); check(v == 8'h7F, "R9 sec msb", v, 8'h7F);
    // R8 status and UIP not writable
    wr(4'hC, 8'hF0); peek(4'hC, v); check(v == 8'h00, "R8 status write", v, 0);
    wr(4'hA, 8'hA6); peek(4'hA, v); check(v == 8'h26, "R8 UIP write", v, 8'h26);

    // R1 divider not running
    wr(4'hA, 8'h30); pulse_tick; wait_cyc(3);
    check(!uip, "R1 divider blocks", uip, 0);
    // R1 SET blocks
    wr(4'hA, 8'h20); wr(4'hB, 8'h80); pulse_tick; wait_cyc(3);
    check(!uip, "R1 SET blocks", uip, 0);
    wr(4'hB, 8'h10);

    // R2/R4 exact timing
    wr(4'h0, 8'd9); wr(4'h1, 8'd40);
    pulse_tick;                       // N0
    check(uip, "R2 UIP on tick", uip, 1);
    wait_cyc(100);
    tick = 1'b1; wait_cyc(1); tick = 1'b0;   // N101, ignored tick
    wait_cyc(142);                    // N243
    peek(4'h0, v); check(v == 8'd9, "R2 before load", v, 9);
    wait_cyc(1);                      // N244
    peek(4'h0, v); check(v == 8'd10, "R2 after load", v, 10);
    wait_cyc(1983);                   // N2227
    peek(4'hC, v); check(v == 8'h00 && uip, "R4 before end", {v, uip}, 1);
    wait_cyc(1);                      // N2228
    peek(4'hC, v); check(v == 8'h90 && !uip, "R4 UF and UIP", {v, uip}, 16'h9000);
    check(irq, "R5 irq on UF", irq, 1);
    wait_cyc(3000);
    check(!uip, "R4 no restart from ignored tick", uip, 0);

    // R6 read-to-clear
    rd_stat(v); check(v == 8'h90, "R6 read value", v, 8'h90);
    peek(4'hC, v); check(v == 8'h00 && !irq, "R6 cleared", {v, irq}, 0);

    // R7 SET during first phase
    pulse_tick; wait_cyc(10);
    wr(4'hB, 8'h90);
    peek(4'hB, v); check(v == 8'h80, "R7 UIE forced 0", v, 8'h80);
    check(!uip, "R7 UIP cleared", uip, 1'b0);
    wait_cyc(3000);
    peek(4'h0, v); check(v == 8'd10, "R7 no time advance", v, 10);
    peek(4'hC, v); check(v == 8'h00, "R7 no UF", v, 0);
    wr(4'hB, 8'h00);

    // R3/R5 random update cycles
    for (int i = 0; i < 6; i++) begin
      sec0 = (i == 0) ? 8'd59 : 8'($urandom_range(0, 58));
      min0 = (i == 0) ? 8'd59 : 8'($urandom_range(0, 59));
      hit  = (i == 0) ? 1'b1 : 1'($urandom_range(0, 1));
      mis  = 1'($urandom_range(0, 1));
      b    = {1'b0, 3'($urandom_range(0, 7)), 4'h0};
      asec = (sec0 == 8'd59) ? 8'd0 : sec0 + 8'd1;
      amin = (sec0 == 8'd59) ? ((min0 == 8'd59) ? 8'd0 : min0 + 8'd1) : min0;
      wr(4'h0, sec0); wr(4'h2, min0);
      wr(4'h4, 8'd7); wr(4'h6, 8'd3); wr(4'h7, 8'd11);
      wr(4'h5, 8'd7); wr(4'h9, 8'd11);
      wr(4'h8, (hit || mis) ? 8'd3 : 8'd4);
      wr(4'h1, (hit || !mis) ? asec : asec + 8'd1);
      wr(4'h3, amin);
      wr(4'hB, b);
      rd_stat(v);
      pulse_tick;
      wait_cyc(2229);
      peek(4'h0, v); check(v == asec, "R2 sec stub", v, asec);
      peek(4'h2, v); check(v == amin, "R2 min carry", v, amin);
      peek(4'hC, v);
      check(v == {exp_irq(b, {1'b0, hit, 1'b1}), 1'b0, hit, 1'b1, 4'h0},
            "R3 alarm compare", v, {exp_irq(b, {1'b0, hit, 1'b1}), 1'b0, hit, 1'b1, 4'h0});
      check(irq == exp_irq(b, {1'b0, hit, 1'b1}), "R5 irq mask", irq, exp_irq(b, {1'b0, hit, 1'b1}));
    end

    // R5 enable after pending
    wr(4'hB, 8'h00);
    check(!irq, "R5 disabled", irq, 0);
    wr(4'hB, 8'h10);
    peek(4'hC, v); check(irq && v[7], "R5 enable raises", {irq, v[7]}, 3);
    rd_stat(v);

    // R10 periodic
    wr(4'hB, 8'h00);
    wr(4'hA, 8'h23);                  // rate 3, period 4
    wait_cyc(3); peek(4'hC, v); check(!v[6], "R10 before PF", v, 0);
    wait_cyc(1); peek(4'hC, v); check(v[6] && !irq, "R10 PF rate3", {v[6], irq}, 2);
    wr(4'hB, 8'h40); check(irq, "R5 PIE raises", irq, 1);
    wr(4'hB, 8'h00); wr(4'hA, 8'h20); rd_stat(v);
    wr(4'hA, 8'h21);                  // rate 1 acts as 8: 128
    wait_cyc(127); peek(4'hC, v); check(!v[6], "R10 rate1 early", v, 0);
    wait_cyc(1); peek(4'hC, v); check(v[6], "R10 rate1 as 8", v, 8'h40);
    wr(4'hA, 8'h20); rd_stat(v);
    wait_cyc(300); peek(4'hC, v); check(v == 8'h00, "R10 rate0 off", v, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule